// File: doc/BRIEF.md
# Cross-Clock Mailbox Pair

Two single-word mailboxes carry short control words between two clock domains that have no fixed phase relation to each other. Box 1 is loaded from port A and unloaded on port B; box 2 is loaded from port B and unloaded on port A. Neither box passes through any queue storage. Port A and port B use the same access decode, built from an active-low chip select, a write/read select, an enable and a mailbox select.

On the writing side, each box has an active-low occupancy flag. On the reading side, it has a "word waiting" indication. A write latches the word and marks the box occupied. The write event then crosses to the reader through a toggle and a synchroniser. A read takes the word into the reader's output register and sends an acknowledge toggle back to the writer, which frees the box. The writer may not overwrite a word until that acknowledge has arrived.

Top module: `mbox_xclk`

## Requirements
- R1: After reset, both occupancy flags (a_m1_full_no, b_m2_full_no) are 1, both waiting indications (b_m1_valid_o, a_m2_valid_o) are 0, and both read data outputs are 0.
- R2: On a clk_a_i rising edge with a_cs_ni=0, a_wr_i=1, a_en_i=1, a_mb_i=1 and a_m1_full_no=1, a_data_i is stored in box 1 and a_m1_full_no goes to 0 after that edge.
- R3: On a clk_b_i rising edge with b_cs_ni=0, b_wr_i=1, b_en_i=1, b_mb_i=1 and b_m2_full_no=1, b_data_i is stored in box 2 and b_m2_full_no goes to 0 after that edge.
- R4: Any other combination of chip select, write/read select, enable and mailbox select is not a write, and it leaves the flag and the reader's view unchanged. In particular, toggling chip select or write/read select while enable is 0 does nothing.
- R5: A write to a box whose flag is 0 is ignored; the reader later receives the earlier word.
- R6: After a write, the reader's waiting indication rises within 6 reader clock cycles.
- R7: A read of box 1 (b_cs_ni=0, b_wr_i=0, b_en_i=1, b_mb_i=1) while b_m1_valid_o=1 loads the word onto b_data_o and clears b_m1_valid_o after that edge. A read with b_m1_valid_o=0 leaves b_data_o unchanged.
- R8: After a read, the writer's flag returns to 1 within 6 writer clock cycles.
- R9: A read of box 2 on port A (a_cs_ni=0, a_wr_i=0, a_en_i=1, a_mb_i=1) behaves like R7, using a_m2_valid_o and a_data_o.
- R10: The two boxes work independently, and transfers in both directions may overlap in time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a_i | input | 1 | Port A clock |
| clk_b_i | input | 1 | Port B clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_cs_ni | input | 1 | Port A chip select, active low |
| a_wr_i | input | 1 | Port A 1=write, 0=read |
| a_en_i | input | 1 | Port A enable |
| a_mb_i | input | 1 | Port A mailbox select |
| a_data_i | input | DATA_W | Word written into box 1 |
| a_data_o | output | DATA_W | Last word read from box 2 |
| a_m1_full_no | output | 1 | Box 1 occupied, active low |
| a_m2_valid_o | output | 1 | Box 2 holds an unread word |
| b_cs_ni | input | 1 | Port B chip select, active low |
| b_wr_i | input | 1 | Port B 1=write, 0=read |
| b_en_i | input | 1 | Port B enable |
| b_mb_i | input | 1 | Port B mailbox select |
| b_data_i | input | DATA_W | Word written into box 2 |
| b_data_o | output | DATA_W | Last word read from box 1 |
| b_m2_full_no | output | 1 | Box 2 occupied, active low |
| b_m1_valid_o | output | 1 | Box 1 holds an unread word |

## Verification
The bench applies every non-write decode combination and confirms that none of them marks a box occupied. A design that decoded one select too loosely would drop a flag or deliver a false word. It writes a second word into an occupied box and checks that the reader still receives the first; a design without write lockout would hand over the overwritten word. It also reads a box that holds no word, and runs both directions at once with the two clocks out of step. A design that let an empty read refresh the output, or that mixed up the two handshakes, would show a changed output word or a flag that never clears.

// File: rtl/mbox_pkg.sv
`timescale 1ns/1ps
package mbox_pkg;
  typedef enum logic [1:0] {MB_IDLE, MB_WRITE, MB_READ} mb_op_e;

  function automatic mb_op_e mb_decode(input logic cs_n, input logic wr,
                                       input logic en, input logic mb);
    if (!en || cs_n || !mb) return MB_IDLE;
    return wr ? MB_WRITE : MB_READ;
  endfunction
endpackage

// File: rtl/mbox_port_dec.sv
`timescale 1ns/1ps
module mbox_port_dec
  import mbox_pkg::*;
(
  input  logic cs_ni,
  input  logic wr_i,
  input  logic en_i,
  input  logic mb_i,
  output logic wr_stb_o,
  output logic rd_stb_o
);
  mb_op_e op;
  always_comb begin
    op       = mb_decode(cs_ni, wr_i, en_i, mb_i);
    wr_stb_o = (op == MB_WRITE);
    rd_stb_o = (op == MB_READ);
  end
endmodule

// File: rtl/mbox_sync.sv
`timescale 1ns/1ps
module mbox_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int LAST = STAGES - 1;
  logic [LAST:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[i] <= 1'b0;
        else if (i == 0) chain_q[i] <= d_i;
        else chain_q[i] <= chain_q[(i == 0) ? 0 : i - 1];
      end
    end
  endgenerate

  assign q_o = chain_q[LAST];
endmodule

// File: rtl/mbox_channel.sv
`timescale 1ns/1ps
module mbox_channel #(
  parameter int W           = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk_w_i,
  input  logic         clk_r_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic         full_no,
  input  logic         rd_i,
  output logic [W-1:0] rdata_o,
  output logic         valid_o
);
  logic [W-1:0] store_q, rdata_q;
  logic full_q, req_tgl_q, ack_seen_q;
  logic valid_q, ack_tgl_q, req_seen_q;
  logic req_sync, ack_sync;
  logic wr_ok, rd_ok, ack_evt, req_evt;

  // writer domain
  assign ack_evt = ack_sync ^ ack_seen_q;
  assign wr_ok   = wr_i & ~full_q;

  always_ff @(posedge clk_w_i or negedge rst_ni) begin
    if (!rst_ni) begin
      store_q    <= '0;
      full_q     <= 1'b0;
      req_tgl_q  <= 1'b0;
      ack_seen_q <= 1'b0;
    end else begin
      ack_seen_q <= ack_sync;
      if (wr_ok) begin
        store_q   <= wdata_i;
        full_q    <= 1'b1;
        req_tgl_q <= ~req_tgl_q;
      end else if (ack_evt) begin
        full_q <= 1'b0;
      end
    end
  end

  mbox_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk_i (clk_w_i),
    .rst_ni(rst_ni),
    .d_i   (ack_tgl_q),
    .q_o   (ack_sync)
  );

  // reader domain; store_q is frozen while the box is occupied
  assign req_evt = req_sync ^ req_seen_q;
  assign rd_ok   = rd_i & valid_q;

  always_ff @(posedge clk_r_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q    <= '0;
      valid_q    <= 1'b0;
      ack_tgl_q  <= 1'b0;
      req_seen_q <= 1'b0;
    end else begin
      req_seen_q <= req_sync;
      if (rd_ok) begin
        rdata_q   <= store_q;
        valid_q   <= 1'b0;
        ack_tgl_q <= ~ack_tgl_q;
      end else if (req_evt) begin
        valid_q <= 1'b1;
      end
    end
  end

  mbox_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk_i (clk_r_i),
    .rst_ni(rst_ni),
    .d_i   (req_tgl_q),
    .q_o   (req_sync)
  );

  assign full_no = ~full_q;
  assign rdata_o = rdata_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/mbox_xclk.sv
`timescale 1ns/1ps
module mbox_xclk #(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_a_i,
  input  logic              clk_b_i,
  input  logic              rst_ni,
  input  logic              a_cs_ni,
  input  logic              a_wr_i,
  input  logic              a_en_i,
  input  logic              a_mb_i,
  input  logic [DATA_W-1:0] a_data_i,
  output logic [DATA_W-1:0] a_data_o,
  output logic              a_m1_full_no,
  output logic              a_m2_valid_o,
  input  logic              b_cs_ni,
  input  logic              b_wr_i,
  input  logic              b_en_i,
  input  logic              b_mb_i,
  input  logic [DATA_W-1:0] b_data_i,
  output logic [DATA_W-1:0] b_data_o,
  output logic              b_m2_full_no,
  output logic              b_m1_valid_o
);
  logic a_wr_stb, a_rd_stb, b_wr_stb, b_rd_stb;

  mbox_port_dec u_dec_a (
    .cs_ni(a_cs_ni), .wr_i(a_wr_i), .en_i(a_en_i), .mb_i(a_mb_i),
    .wr_stb_o(a_wr_stb), .rd_stb_o(a_rd_stb)
  );

  mbox_port_dec u_dec_b (
    .cs_ni(b_cs_ni), .wr_i(b_wr_i), .en_i(b_en_i), .mb_i(b_mb_i),
    .wr_stb_o(b_wr_stb), .rd_stb_o(b_rd_stb)
  );

  // box 1: A -> B
  mbox_channel #(.W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_box1 (
    .clk_w_i(clk_a_i),  .clk_r_i(clk_b_i), .rst_ni(rst_ni),
    .wr_i   (a_wr_stb), .wdata_i(a_data_i), .full_no(a_m1_full_no),
    .rd_i   (b_rd_stb), .rdata_o(b_data_o), .valid_o(b_m1_valid_o)
  );

  // box 2: B -> A
  mbox_channel #(.W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_box2 (
    .clk_w_i(clk_b_i),  .clk_r_i(clk_a_i), .rst_ni(rst_ni),
    .wr_i   (b_wr_stb), .wdata_i(b_data_i), .full_no(b_m2_full_no),
    .rd_i   (a_rd_stb), .rdata_o(a_data_o), .valid_o(a_m2_valid_o)
  );
endmodule

// File: rtl/mbox_xclk_chk.sv
`timescale 1ns/1ps
module mbox_xclk_chk #(
  parameter int W = 32
) (
  input logic         clk_a_i,
  input logic         clk_b_i,
  input logic         rst_ni,
  input logic         a_cs_ni,
  input logic         a_wr_i,
  input logic         a_en_i,
  input logic         a_mb_i,
  input logic [W-1:0] a_data_o,
  input logic         a_m1_full_no,
  input logic         a_m2_valid_o,
  input logic         b_cs_ni,
  input logic         b_wr_i,
  input logic         b_en_i,
  input logic         b_mb_i,
  input logic [W-1:0] b_data_o,
  input logic         b_m2_full_no,
  input logic         b_m1_valid_o
);
  logic a_wr_hit, a_rd_hit, b_wr_hit, b_rd_hit;
  assign a_wr_hit = a_en_i & ~a_cs_ni & a_mb_i & a_wr_i;
  assign a_rd_hit = a_en_i & ~a_cs_ni & a_mb_i & ~a_wr_i;
  assign b_wr_hit = b_en_i & ~b_cs_ni & b_mb_i & b_wr_i;
  assign b_rd_hit = b_en_i & ~b_cs_ni & b_mb_i & ~b_wr_i;

  // R2
  m1_write_marks_full_chk: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (a_wr_hit && a_m1_full_no) |=> !a_m1_full_no);
  // R3
  m2_write_marks_full_chk: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    (b_wr_hit && b_m2_full_no) |=> !b_m2_full_no);
  // R4
  m1_no_write_keeps_free_chk: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (!a_wr_hit && a_m1_full_no) |=> a_m1_full_no);
  // R4
  m2_no_write_keeps_free_chk: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    (!b_wr_hit && b_m2_full_no) |=> b_m2_full_no);
  // R7
  m1_read_consumes_chk: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    (b_rd_hit && b_m1_valid_o) |=> !b_m1_valid_o);
  // R7
  m1_rdata_hold_chk: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    !(b_rd_hit && b_m1_valid_o) |=> $stable(b_data_o));
  // R9
  m2_read_consumes_chk: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (a_rd_hit && a_m2_valid_o) |=> !a_m2_valid_o);
  // R9
  m2_rdata_hold_chk: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    !(a_rd_hit && a_m2_valid_o) |=> $stable(a_data_o));
endmodule

bind mbox_xclk mbox_xclk_chk #(.W(DATA_W)) u_chk (.*);

// File: tb/sim_mbox_xclk.sv
`timescale 1ns/1ps
module sim_mbox_xclk;
  localparam int CLK_PERIOD   = 10;
  localparam int CLK_B_PERIOD = CLK_PERIOD * 7 / 5;
  localparam int W            = 32;
  localparam int LAT_MAX      = 6;

  logic clk_a = 1'b0, clk_b = 1'b0, rst_n = 1'b0;
  logic a_cs_n = 1'b1, a_wr = 1'b0, a_en = 1'b0, a_mb = 1'b0;
  logic b_cs_n = 1'b1, b_wr = 1'b0, b_en = 1'b0, b_mb = 1'b0;
  logic [W-1:0] a_din = '0, b_din = '0, a_dout, b_dout;
  logic a_m1_full_n, a_m2_valid, b_m2_full_n, b_m1_valid;
  int n_cmp = 0, n_bad = 0;

  always #(CLK_PERIOD / 2) clk_a = ~clk_a;
  always #(CLK_B_PERIOD / 2) clk_b = ~clk_b;

  mbox_xclk #(.DATA_W(W)) u0 (
    .clk_a_i(clk_a), .clk_b_i(clk_b), .rst_ni(rst_n),
    .a_cs_ni(a_cs_n), .a_wr_i(a_wr), .a_en_i(a_en), .a_mb_i(a_mb),
    .a_data_i(a_din), .a_data_o(a_dout), .a_m1_full_no(a_m1_full_n),
    .a_m2_valid_o(a_m2_valid),
    .b_cs_ni(b_cs_n), .b_wr_i(b_wr), .b_en_i(b_en), .b_mb_i(b_mb),
    .b_data_i(b_din), .b_data_o(b_dout), .b_m2_full_no(b_m2_full_n),
    .b_m1_valid_o(b_m1_valid)
  );

  function automatic bit is_write(input bit cs_n, input bit wr, input bit en, input bit mb);
    return !cs_n && wr && en && mb;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // pb=0 -> port A, pb=1 -> port B; returns at the falling edge after the sampling edge
  task automatic port_op(input bit pb, input bit cs_n, input bit wr, input bit en,
                         input bit mb, input logic [W-1:0] d);
    if (!pb) begin
      @(negedge clk_a);
      a_cs_n = cs_n; a_wr = wr; a_en = en; a_mb = mb; a_din = d;
      @(negedge clk_a);
      a_cs_n = 1'b1; a_wr = 1'b0; a_en = 1'b0; a_mb = 1'b0;
    end else begin
      @(negedge clk_b);
      b_cs_n = cs_n; b_wr = wr; b_en = en; b_mb = mb; b_din = d;
      @(negedge clk_b);
      b_cs_n = 1'b1; b_wr = 1'b0; b_en = 1'b0; b_mb = 1'b0;
    end
  endtask

  function automatic logic rd_valid(input bit pb_writer);
    return pb_writer ? a_m2_valid : b_m1_valid;
  endfunction
  function automatic logic wr_free(input bit pb_writer);
    return pb_writer ? b_m2_full_n : a_m1_full_n;
  endfunction
  function automatic logic [W-1:0] rd_data(input bit pb_writer);
    return pb_writer ? a_dout : b_dout;
  endfunction

  // R6: waiting indication reaches the reader within LAT_MAX reader cycles
  task automatic wait_valid(input bit pb_writer);
    int n = 0;
    while (rd_valid(pb_writer) !== 1'b1 && n < 3 * LAT_MAX) begin
      if (pb_writer) @(negedge clk_a); else @(negedge clk_b);
      n++;
    end
    chk(rd_valid(pb_writer) === 1'b1 && n <= LAT_MAX, "R6", n, LAT_MAX);
  endtask

  // R8: flag returns to 1 within LAT_MAX writer cycles
  task automatic wait_free(input bit pb_writer);
    int n = 0;
    while (wr_free(pb_writer) !== 1'b1 && n < 3 * LAT_MAX) begin
      if (pb_writer) @(negedge clk_b); else @(negedge clk_a);
      n++;
    end
    chk(wr_free(pb_writer) === 1'b1 && n <= LAT_MAX, "R8", n, LAT_MAX);
  endtask

  task automatic transfer(input bit pb_writer, input logic [W-1:0] word, input int extra);
    port_op(pb_writer, 1'b0, 1'b1, 1'b1, 1'b1, word);
    chk(wr_free(pb_writer) === 1'b0, pb_writer ? "R3" : "R2", wr_free(pb_writer), 0);
    for (int i = 0; i < extra; i++) begin
      port_op(pb_writer, 1'b0, 1'b1, 1'b1, 1'b1, $urandom);
      chk(wr_free(pb_writer) === 1'b0, "R5", wr_free(pb_writer), 0);
    end
    wait_valid(pb_writer);
    port_op(!pb_writer, 1'b0, 1'b0, 1'b1, 1'b1, '0);
    chk(rd_data(pb_writer) === word, pb_writer ? "R9" : "R7", rd_data(pb_writer), word);
    chk(rd_valid(pb_writer) === 1'b0, pb_writer ? "R9" : "R7", rd_valid(pb_writer), 0);
    wait_free(pb_writer);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [W-1:0] held;
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk_b);
    // R1
    chk(a_m1_full_n === 1'b1 && b_m2_full_n === 1'b1, "R1", {a_m1_full_n, b_m2_full_n}, 2'b11);
    chk(a_m2_valid === 1'b0 && b_m1_valid === 1'b0, "R1", {a_m2_valid, b_m1_valid}, 0);
    chk(a_dout === '0 && b_dout === '0, "R1", a_dout | b_dout, 0);
    @(negedge clk_a); rst_n = 1'b1;
    repeat (2) @(negedge clk_a);

    // R4: every non-write decode on both ports
    for (int c = 0; c < 16; c++) begin
      if (!is_write(c[3], c[2], c[1], c[0])) begin
        port_op(1'b0, c[3], c[2], c[1], c[0], 32'hdead0000 | c);
        chk(a_m1_full_n === 1'b1, "R4", a_m1_full_n, 1);
        port_op(1'b1, c[3], c[2], c[1], c[0], 32'hbeef0000 | c);
        chk(b_m2_full_n === 1'b1, "R4", b_m2_full_n, 1);
      end
    end
    repeat (LAT_MAX + 2) @(negedge clk_b);
    chk(b_m1_valid === 1'b0 && a_m2_valid === 1'b0, "R4", {b_m1_valid, a_m2_valid}, 0);
    chk(a_dout === '0 && b_dout === '0, "R4", a_dout | b_dout, 0);

    // R2 R5 R6 R7 R8: directed, with a rejected overwrite
    transfer(1'b0, 32'h1234_5678, 2);
    // R7: read with nothing waiting keeps output
    port_op(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, '0);
    chk(b_dout === 32'h1234_5678, "R7", b_dout, 32'h1234_5678);
    // R3 R9
    transfer(1'b1, 32'hcafe_f00d, 1);
    port_op(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, '0);
    chk(a_dout === 32'hcafe_f00d, "R9", a_dout, 32'hcafe_f00d);
    // R2 boundary words
    transfer(1'b0, '1, 0);
    transfer(1'b1, '0, 0);

    // R10: both directions overlapping
    fork
      transfer(1'b0, 32'haaaa_5555, 1);
      transfer(1'b1, 32'h5555_aaaa, 1);
    join
    chk(b_dout === 32'haaaa_5555, "R10", b_dout, 32'haaaa_5555);
    chk(a_dout === 32'h5555_aaaa, "R10", a_dout, 32'h5555_aaaa);

    // random: stray non-write decodes, then a transfer with rejected overwrites
    for (int it = 0; it < 40; it++) begin
      bit pb = $urandom_range(1, 0);
      bit cs_n = $urandom_range(1, 0), wr = $urandom_range(1, 0);
      bit en = $urandom_range(1, 0), mb = $urandom_range(1, 0);
      if (is_write(cs_n, wr, en, mb)) en = 1'b0;
      held = rd_data(pb);
      port_op(pb, cs_n, wr, en, mb, $urandom);
      chk(wr_free(pb) === 1'b1, "R4", wr_free(pb), 1);
      chk(rd_data(pb) === held, "R4", rd_data(pb), held);
      transfer(pb, $urandom, $urandom_range(2, 0));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule